// File: doc/BRIEF.md
# Multiplexed LCD Duty Sequencer

This block generates the time-multiplexed drive codes for a liquid-crystal panel that has five common electrodes and eighty segment electrodes. A single-cycle tick from an external oscillator moves the scan to its next phase. Two select pins set the duty to one third, one quarter or one fifth. The duty sets how many commons take part in the scan. For each phase, the block picks one common as the selected electrode. It sends the matching row of the five-row display store, which the user supplies, to the segment outputs.

Every output pin carries a 2-bit code. The code names one of four bias rails, from highest to lowest: 0 = top supply, 1 = upper middle, 2 = lower middle, 3 = bottom. Each full scan flips a frame polarity, so no electrode pair sees a DC bias over time. An active-low blank input turns every segment off and leaves the row store untouched. The analog rail switches, the oscillator and the serial loader of the row store are all outside this block. The block has no streaming data path, so every pin is a plain level or strobe.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset, the phase is 0 and the polarity is 0. COM1 drives code 0 and every other common drives code 2.
- R2: `duty_sel` sets the scan length. 2'b00 gives 3 phases, 2'b01 gives 4 phases, and 2'b10 or 2'b11 give 5 phases (bit 0 is ignored when bit 1 is high).
- R3: Each cycle with `osc_tick` high moves the phase up by one, wrapping from N-1 to 0. In a cycle without a tick, the phase and polarity do not change.
- R4: The polarity toggles on the tick that wraps the phase from N-1 to 0, and on no other tick.
- R5: At polarity 0, the selected common drives code 0 (top) and the unselected commons drive code 2. At polarity 1, the selected common drives code 3 (bottom) and the unselected commons drive code 1. Common k is selected in phase k.
- R6: A common whose index is N or higher never shows the select level. With N=3 this is COM4 and COM5, and with N=4 it is COM5.
- R7: In phase k, segment i is ON when `row_bits[k*80+i]` is 1. At polarity 0, ON drives code 3 and OFF drives code 1. At polarity 1, ON drives code 0 and OFF drives code 2.
- R8: While `blank_n` is low, every segment drives the OFF code for the current polarity and the commons keep scanning. When `blank_n` returns high, the segments show the row data again.
- R9: A tick that arrives when `duty_sel` decodes to a scan length different from the one in use sets the phase to 0. That tick adopts the new length and keeps the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle scan-advance strobe from the oscillator |
| duty_sel | input | 2 | Duty select; bit 1 high selects five phases, otherwise bit 0 picks four (1) or three (0) |
| blank_n | input | 1 | Active-low blank; low forces all segments OFF |
| row_bits | input | 400 | Display store, row k in bits k*80 to k*80+79 |
| com_code | output | 10 | Rail code of common k in bits 2k+1:2k |
| seg_code | output | 160 | Rail code of segment i in bits 2i+1:2i |

## Verification
The assertions assume that `osc_tick` is a clean synchronous strobe. They also assume that `duty_sel` and `blank_n` change only between clock edges and do not glitch within a cycle, so each tick sees one well-defined scan length. The bench drives every input on the falling clock edge and holds `osc_tick` high for exactly one cycle. It changes `duty_sel` only while no tick is pending, so every duty switch reaches the block as a single clean step that the next tick takes up.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  // Bias rails, highest potential first
  typedef enum logic [1:0] {
    RAIL_TOP    = 2'd0,
    RAIL_HI_MID = 2'd1,
    RAIL_LO_MID = 2'd2,
    RAIL_BOT    = 2'd3
  } rail_e;

  localparam int unsigned DUTY_MIN = 3;
  localparam int unsigned DUTY_MAX = 5;

  // Scan length selected by the duty pins
  function automatic int unsigned duty_phases(input logic [1:0] sel);
    if (sel[1])      return DUTY_MAX;
    else if (sel[0]) return DUTY_MIN + 1;
    else             return DUTY_MIN;
  endfunction

endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 5,
  parameter int unsigned CNT_W   = $clog2(NUM_COM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [1:0]       duty_sel,
  output logic [CNT_W-1:0] phase,
  output logic             polarity,
  output logic [CNT_W-1:0] n_active
);

  logic [CNT_W-1:0] n_req;
  logic             at_last;

  assign n_req   = CNT_W'(duty_phases(duty_sel));
  assign at_last = (phase == n_active - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      polarity <= 1'b0;
      n_active <= CNT_W'(DUTY_MAX);
    end else if (osc_tick) begin
      if (n_req != n_active) begin
        n_active <= n_req;
        phase    <= '0;
      end else if (at_last) begin
        phase    <= '0;
        polarity <= ~polarity;
      end else begin
        phase    <= phase + CNT_W'(1);
      end
    end
  end

  // R3: phase stays inside the active scan
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < n_active);

  // R3: no tick, no movement
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(phase) && $stable(polarity));

  // R4: wrap flips the frame polarity
  a_r4_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick && (n_req == n_active) && at_last |=> (phase == '0) && (polarity != $past(polarity)));

  // R9: duty change restarts the scan, polarity kept
  a_r9_duty_restart: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick && (n_req != n_active) |=> (phase == '0) && $stable(polarity));

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 5,
  parameter int unsigned CNT_W   = $clog2(NUM_COM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   phase,
  input  logic               polarity,
  input  logic [CNT_W-1:0]   n_active,
  output logic [2*NUM_COM-1:0] com_code
);

  logic [NUM_COM-1:0] shows_select;

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    logic  picked;
    rail_e code;

    assign picked = (CNT_W'(k) < n_active) && (phase == CNT_W'(k));

    always_comb begin
      if (polarity) code = picked ? RAIL_BOT : RAIL_HI_MID;
      else          code = picked ? RAIL_TOP : RAIL_LO_MID;
    end

    assign com_code[2*k +: 2] = code;
    assign shows_select[k]    = (com_code[2*k +: 2] == (polarity ? RAIL_BOT : RAIL_TOP));

    // R6: commons outside the scan never show select
    a_r6_idle_common: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(k) >= n_active) |-> !shows_select[k]);
  end

  // R5: exactly one common at the select level
  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(shows_select) == 1);

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 5,
  parameter int unsigned NUM_SEG = 80,
  parameter int unsigned CNT_W   = $clog2(NUM_COM + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           phase,
  input  logic                       polarity,
  input  logic                       blank_n,
  input  logic [NUM_COM*NUM_SEG-1:0] row_bits,
  output logic [2*NUM_SEG-1:0]       seg_code
);

  logic [NUM_SEG-1:0] row_sel;
  logic [NUM_SEG-1:0] is_on_level;
  logic [NUM_SEG-1:0] is_common_side;

  always_comb begin
    row_sel = '0;
    for (int k = 0; k < NUM_COM; k++) begin
      if (phase == CNT_W'(k)) row_sel = row_bits[k*NUM_SEG +: NUM_SEG];
    end
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic  lit;
    rail_e code;

    assign lit = row_sel[i] & blank_n;

    always_comb begin
      if (polarity) code = lit ? RAIL_TOP : RAIL_LO_MID;
      else          code = lit ? RAIL_BOT : RAIL_HI_MID;
    end

    assign seg_code[2*i +: 2]  = code;
    assign is_on_level[i]      = (seg_code[2*i +: 2] == (polarity ? RAIL_TOP : RAIL_BOT));
    assign is_common_side[i]   = (seg_code[2*i +: 2] == (polarity ? RAIL_BOT : RAIL_TOP)) ||
                                 (seg_code[2*i +: 2] == (polarity ? RAIL_HI_MID : RAIL_LO_MID));
  end

  // R8: blank leaves no segment lit
  a_r8_blank_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (is_on_level == '0));

  // R7: segments use only the rails opposite the commons
  a_r7_segment_rails: assert property (@(posedge clk) disable iff (!rst_n)
    is_common_side == '0);

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 5,
  parameter int unsigned NUM_SEG = 80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_tick,
  input  logic [1:0]                 duty_sel,
  input  logic                       blank_n,
  input  logic [NUM_COM*NUM_SEG-1:0] row_bits,
  output logic [2*NUM_COM-1:0]       com_code,
  output logic [2*NUM_SEG-1:0]       seg_code
);

  localparam int unsigned CNT_W = $clog2(NUM_COM + 1);

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] n_active;
  logic             polarity;

  lcd_phase_ctrl #(.NUM_COM(NUM_COM), .CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .duty_sel (duty_sel),
    .phase    (phase),
    .polarity (polarity),
    .n_active (n_active)
  );

  lcd_com_drive #(.NUM_COM(NUM_COM), .CNT_W(CNT_W)) u_com (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .polarity (polarity),
    .n_active (n_active),
    .com_code (com_code)
  );

  lcd_seg_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .CNT_W(CNT_W)) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .polarity (polarity),
    .blank_n  (blank_n),
    .row_bits (row_bits),
    .seg_code (seg_code)
  );

endmodule

// File: tb/test_lcd_mux_sequencer.sv
module test_lcd_mux_sequencer;
  localparam int NC = 5;
  localparam int NS = 80;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             osc_tick;
  logic [1:0]       duty_sel;
  logic             blank_n;
  logic [NC*NS-1:0] row_bits;
  logic [2*NC-1:0]  com_code;
  logic [2*NS-1:0]  seg_code;

  int checks = 0;
  int errors = 0;
  int m_ph, m_pol, m_n;

  lcd_mux_sequencer i_lcd_mux_sequencer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .duty_sel(duty_sel),
    .blank_n(blank_n), .row_bits(row_bits), .com_code(com_code), .seg_code(seg_code)
  );

  function automatic int dec_n(logic [1:0] s);
    return s[1] ? 5 : (s[0] ? 4 : 3);
  endfunction

  function automatic logic [2*NC-1:0] exp_com();
    logic [2*NC-1:0] v;
    for (int k = 0; k < NC; k++) begin
      if (k < m_n && k == m_ph) v[2*k +: 2] = m_pol ? 2'd3 : 2'd0;
      else                      v[2*k +: 2] = m_pol ? 2'd1 : 2'd2;
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg();
    logic [2*NS-1:0] v;
    for (int i = 0; i < NS; i++) begin
      logic on;
      on = row_bits[m_ph*NS + i] && blank_n;
      v[2*i +: 2] = m_pol ? (on ? 2'd0 : 2'd2) : (on ? 2'd3 : 2'd1);
    end
    return v;
  endfunction

  task automatic check(string req);
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    ec = exp_com();
    es = exp_seg();
    checks++;
    if (com_code !== ec || seg_code !== es) begin
      errors++;
      $display("FAIL %s: com=%h exp=%h seg=%h exp=%h", req, com_code, ec, seg_code, es);
    end
  endtask

  task automatic model_tick();
    int nn;
    nn = dec_n(duty_sel);
    if (nn != m_n) begin
      m_n = nn; m_ph = 0;
    end else if (m_ph == m_n - 1) begin
      m_ph = 0; m_pol = 1 - m_pol;
    end else begin
      m_ph++;
    end
  endtask

  task automatic tick_and_check(string req);
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    model_tick();
    check(req);
  endtask

  task automatic fill_rows(int seed);
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < NS; i++)
        row_bits[k*NS + i] = (((i * 7 + k * 3 + seed) % 5) < 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; osc_tick = 1'b0; duty_sel = 2'b10; blank_n = 1'b1;
    fill_rows(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_ph = 0; m_pol = 0; m_n = 5;
    @(negedge clk);
    check("R1 reset state");
  endtask

  task automatic t_scan5();
    for (int t = 0; t < 12; t++) tick_and_check("R3 R4 R5 R7 five-phase scan");
  endtask

  task automatic t_hold();
    repeat (6) @(negedge clk);
    check("R3 hold without tick");
  endtask

  task automatic t_duty4();
    fill_rows(2);
    @(negedge clk) duty_sel = 2'b01;
    check("R9 no change before tick");
    tick_and_check("R9 duty change restart");
    for (int t = 0; t < 9; t++) tick_and_check("R2 R6 four-phase scan");
  endtask

  task automatic t_duty3();
    @(negedge clk) duty_sel = 2'b00;
    tick_and_check("R9 switch to three phases");
    for (int t = 0; t < 7; t++) tick_and_check("R2 R6 three-phase scan");
  endtask

  task automatic t_sel11();
    @(negedge clk) duty_sel = 2'b11;
    tick_and_check("R2 select 11 gives five");
    for (int t = 0; t < 6; t++) tick_and_check("R2 five-phase via 11");
  endtask

  task automatic t_blank();
    fill_rows(4);
    @(negedge clk) blank_n = 1'b0;
    @(negedge clk);
    check("R8 blank forces off");
    for (int t = 0; t < 6; t++) tick_and_check("R8 commons scan while blanked");
    @(negedge clk) blank_n = 1'b1;
    @(negedge clk);
    check("R8 data restored");
    tick_and_check("R7 R8 scan after unblank");
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_scan5();
    t_hold();
    t_duty4();
    t_duty3();
    t_sel11();
    t_blank();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule